// File: doc/BRIEF.md
# Zero-Address Shifting Stack Calculator

This block is a small arithmetic unit that keeps its operands in a column of registers used as a last-in first-out stack, in place of a register file. The newest word always sits in one fixed register, slot 0. When a word is pushed, every stored word moves one slot deeper and the new word lands in slot 0. When a word is popped, the deeper words move back up one slot. An add command takes the two newest words, adds them and leaves the sum in slot 0, so the stack gets one entry shorter.

Per clock the block takes at most one of three commands: push (with a data word), pop and add. It reports the word in slot 0, the number of valid entries, the carry out of the most recent add, and one-cycle error pulses for overflow and underflow. Commands that would break the stack's bounds change nothing. The depth and the word width are parameters, with defaults of 8 entries of 16 bits.

Top module: `shift_stack_calc`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, `top_o` is 0, and `carry_o`, `overflow_o` and `underflow_o` are 0.
- R2: A push accepted while `count_o` is below DEPTH sets `top_o` to the pushed word one cycle later and increments `count_o`. Every earlier entry moves one slot deeper, keeping its order.
- R3: A pop accepted while `count_o` is above 0 removes the word in slot 0 and moves every deeper entry up one slot. It decrements `count_o`. An empty stack shows `top_o` as 0.
- R4: A pop while `count_o` is 0 raises `underflow_o` and leaves the count and the contents unchanged.
- R5: A push while `count_o` equals DEPTH raises `overflow_o` and leaves the count and every stored entry unchanged.
- R6: An add while `count_o` is 2 or more replaces the two newest entries with their sum modulo 2^WIDTH in slot 0. The deeper entries move up one slot, `count_o` drops by one, and `carry_o` takes bit WIDTH of the full sum.
- R7: An add while `count_o` is below 2 raises `underflow_o` and changes neither the contents, the count nor `carry_o`.
- R8: When several commands are asserted in the same cycle, only one is taken, by the priority add, then pop, then push. The commands that lose have no effect on the contents, the count or the flags.
- R9: `overflow_o` and `underflow_o` are registered pulses. Each is high for exactly the one cycle after an offending command, and low after any cycle that held no offending command.
- R10: `carry_o` keeps its value through pushes, pops, idle cycles and rejected commands, and changes only when an add is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push command |
| push_data_i | input | WIDTH | Word to push |
| pop_i | input | 1 | Pop command |
| add_i | input | 1 | Add command |
| top_o | output | WIDTH | Word held in slot 0 (0 when the stack is empty) |
| count_o | output | $clog2(DEPTH+1) | Number of valid entries |
| carry_o | output | 1 | Carry out of the last accepted add |
| overflow_o | output | 1 | Pulse: a push was made on a full stack |
| underflow_o | output | 1 | Pulse: a pop or add was made without enough entries |

## Verification
Every result of a command is due in the cycle after the edge that sampled it. The edge that takes the command also loads `top_o`, `count_o`, `carry_o` and both error pulses. The bench drives each command on a falling edge, holds it across exactly one rising edge and compares all five outputs on the following falling edge. It then compares them again after an idle cycle, to confirm that the pulses have dropped and that the carry has held. After each command the stack is drained by pops, so every slot, including the ones a rejected command could have disturbed, is read back through `top_o`.

// File: rtl/shift_stack_pkg.sv
// Package: shared operation type for the shifting stack calculator.
// Assumes one operation per clock; OP_NONE means the column holds.
package shift_stack_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_ADD  = 2'd3
    } stk_op_e;
endpackage

// File: rtl/stk_cmd_pick.sv
// Module: stk_cmd_pick
// Reduces the three command strobes to one requested operation, with
// the fixed priority add > pop > push. Purely combinational; assumes
// the strobes are synchronous to the block clock.
module stk_cmd_pick
    import shift_stack_pkg::*;
(
    input  logic    push_i,
    input  logic    pop_i,
    input  logic    add_i,
    output stk_op_e op_req_o
);
    // Priority selection of the single requested operation.
    always_comb begin
        if (add_i)       op_req_o = OP_ADD;
        else if (pop_i)  op_req_o = OP_POP;
        else if (push_i) op_req_o = OP_PUSH;
        else             op_req_o = OP_NONE;
    end
endmodule

// File: rtl/stk_occupancy.sv
// Module: stk_occupancy
// Tracks how many slots hold valid data, turns a requested operation into
// an accepted one (or none when it would break the bounds), and registers
// one-cycle overflow/underflow pulses. Assumes op_req is already a single op.
module stk_occupancy
    import shift_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_op_e       op_req_i,
    output stk_op_e       op_go_o,
    output logic [CW-1:0] count_o,
    output logic          overflow_o,
    output logic          underflow_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] TWO  = CW'(2);

    logic [CW-1:0] count_q;
    logic          ovf_q;
    logic          udf_q;
    logic          ovf_now;
    logic          udf_now;

    // Bound check of the requested operation against the occupancy.
    always_comb begin
        ovf_now = (op_req_i == OP_PUSH) && (count_q == FULL);
        udf_now = ((op_req_i == OP_POP) && (count_q == '0)) ||
                  ((op_req_i == OP_ADD) && (count_q < TWO));
        op_go_o = (ovf_now || udf_now) ? OP_NONE : op_req_i;
    end

    // Occupancy counter update for accepted operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (op_go_o)
                OP_PUSH: count_q <= count_q + 1'b1;
                OP_POP,
                OP_ADD:  count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Error pulse registers, one cycle after the offending command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_now;
            udf_q <= udf_now;
        end
    end

    assign count_o     = count_q;
    assign overflow_o  = ovf_q;
    assign underflow_o = udf_q;
endmodule

// File: rtl/stk_slot_column.sv
// Module: stk_slot_column
// The register column. Slot 0 is always the top of stack. Push shifts
// every slot one deeper, pop and add shift them one up (add writes the
// sum into slot 0). Vacated bottom slots are cleared to zero, so an empty
// stack reads 0. Assumes op_go is already bounds-checked.
module stk_slot_column
    import shift_stack_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stk_op_e          op_go_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic [WIDTH-1:0] sum_i,
    output logic [WIDTH-1:0] top_o,
    output logic [WIDTH-1:0] second_o
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] from_above;
        logic [WIDTH-1:0] from_below;

        // Neighbour selection: slot 0 takes the pushed word from above,
        // the bottom slot takes zero from below.
        if (i == 0) begin : g_first
            assign from_above = push_data_i;
        end else begin : g_mid_a
            assign from_above = slot_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign from_below = '0;
        end else begin : g_mid_b
            assign from_below = slot_q[i+1];
        end

        // Per-slot shift register update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                case (op_go_i)
                    OP_PUSH: slot_q[i] <= from_above;
                    OP_POP:  slot_q[i] <= from_below;
                    OP_ADD:  slot_q[i] <= (i == 0) ? sum_i : from_below;
                    default: slot_q[i] <= slot_q[i];
                endcase
            end
        end
    end

    assign top_o    = slot_q[0];
    if (DEPTH > 1) begin : g_second
        assign second_o = slot_q[1];
    end else begin : g_no_second
        assign second_o = '0;
    end
endmodule

// File: rtl/stk_adder.sv
// Module: stk_adder
// Adds the two top words modulo 2^WIDTH and keeps the carry of the last
// accepted add in a register. Assumes add_go is high only for accepted adds.
module stk_adder #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_go_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);
    logic [WIDTH:0] full_sum;
    logic           carry_q;

    // Full-width sum of the two top entries.
    always_comb begin
        full_sum = {1'b0, a_i} + {1'b0, b_i};
        sum_o    = full_sum[WIDTH-1:0];
    end

    // Carry register, loaded only on an accepted add.
    always_ff @(posedge clk) begin
        if (!rst_n)        carry_q <= 1'b0;
        else if (add_go_i) carry_q <= full_sum[WIDTH];
        else               carry_q <= carry_q;
    end

    assign carry_o = carry_q;
endmodule

// File: rtl/shift_stack_calc.sv
// Module: shift_stack_calc (top)
// Zero-address calculator on a shifting register stack: push, pop and add,
// one per clock with priority add > pop > push. All outputs are registered
// and reflect a command one cycle after it is sampled.
module shift_stack_calc
    import shift_stack_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    input  logic             add_i,
    output logic [WIDTH-1:0] top_o,
    output logic [CW-1:0]    count_o,
    output logic             carry_o,
    output logic             overflow_o,
    output logic             underflow_o
);
    stk_op_e          op_req;
    stk_op_e          op_go;
    logic [WIDTH-1:0] second_w;
    logic [WIDTH-1:0] sum_w;
    logic             add_go;

    assign add_go = (op_go == OP_ADD);

    stk_cmd_pick u_pick (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .add_i    (add_i),
        .op_req_o (op_req)
    );

    stk_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_req_i    (op_req),
        .op_go_o     (op_go),
        .count_o     (count_o),
        .overflow_o  (overflow_o),
        .underflow_o (underflow_o)
    );

    stk_adder #(.WIDTH(WIDTH)) u_add (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_go_i (add_go),
        .a_i      (top_o),
        .b_i      (second_w),
        .sum_o    (sum_w),
        .carry_o  (carry_o)
    );

    stk_slot_column #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_col (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_go_i     (op_go),
        .push_data_i (push_data_i),
        .sum_i       (sum_w),
        .top_o       (top_o),
        .second_o    (second_w)
    );
endmodule

// File: rtl/shift_stack_calc_checker.sv
// Module: shift_stack_calc_checker
// Property checks for shift_stack_calc, attached with bind. Relates the
// command ports one cycle to the registered outputs one cycle later.
module shift_stack_calc_checker #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic [WIDTH-1:0] push_data_i,
    input logic             pop_i,
    input logic             add_i,
    input logic [WIDTH-1:0] top_o,
    input logic [WIDTH-1:0] second_i,
    input logic [CW-1:0]    count_o,
    input logic             carry_o,
    input logic             overflow_o,
    input logic             underflow_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] TWO  = CW'(2);

    // R2: an accepted push lands on top and grows the count.
    a_r2_push_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !add_i && count_o < FULL) |=>
        (top_o == $past(push_data_i) && count_o == $past(count_o) + 1'b1));

    // R3: an accepted pop moves the second entry to the top.
    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !add_i && count_o != '0) |=>
        (top_o == $past(second_i) && count_o == $past(count_o) - 1'b1));

    // R4: pop on empty pulses underflow, stack stays empty.
    a_r4_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !add_i && count_o == '0) |=> (underflow_o && count_o == '0));

    // R5: push on full pulses overflow and changes nothing.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !add_i && count_o == FULL) |=>
        (overflow_o && $stable(count_o) && $stable(top_o)));

    // R6: accepted add leaves the wrapped sum on top.
    a_r6_add_sums: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && count_o >= TWO) |=>
        (top_o == WIDTH'($past(top_o) + $past(second_i)) &&
         count_o == $past(count_o) - 1'b1));

    // R7 and R8: a short add wins over pop/push and changes nothing.
    a_r7_short_add_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (add_i && count_o < TWO) |=>
        (underflow_o && !overflow_o && $stable(count_o) && $stable(top_o) && $stable(carry_o)));

    // R9: the two pulses never coexist and count stays in range.
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({overflow_o, underflow_o}) && count_o <= FULL);

    // R9: no pulse follows a cycle with no command.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !add_i) |=> (!overflow_o && !underflow_o));

    // R10: carry changes only after an accepted add.
    a_r10_carry_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_i && count_o >= TWO) |=> $stable(carry_o));
endmodule

bind shift_stack_calc shift_stack_calc_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .add_i       (add_i),
    .top_o       (top_o),
    .second_i    (second_w),
    .count_o     (count_o),
    .carry_o     (carry_o),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o)
);

// File: tb/shift_stack_calc_test.sv
`timescale 1ns/1ps
module shift_stack_calc_test;
    localparam int W  = 16;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [W-1:0]  push_data_i = '0;
    logic          pop_i = 1'b0;
    logic          add_i = 1'b0;
    logic [W-1:0]  top_o;
    logic [CW-1:0] count_o;
    logic          carry_o;
    logic          overflow_o;
    logic          underflow_o;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] model[$];
    logic         m_carry;
    logic         m_ovf;
    logic         m_udf;

    always #2 clk = ~clk;

    shift_stack_calc #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .add_i(add_i), .top_o(top_o), .count_o(count_o),
        .carry_o(carry_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare(input string req);
        chk(req, "top",   int'(top_o), (model.size() > 0) ? int'(model[0]) : 0);
        chk(req, "count", int'(count_o), model.size());
        chk(req, "carry", int'(carry_o), int'(m_carry));
        chk(req, "ovf",   int'(overflow_o), int'(m_ovf));
        chk(req, "udf",   int'(underflow_o), int'(m_udf));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        push_i = 1'b0; pop_i = 1'b0; add_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model.delete();
        m_carry = 1'b0; m_ovf = 1'b0; m_udf = 1'b0;
        compare("R1");
    endtask

    // One command cycle: update the model, drive, sample one edge later.
    task automatic step(input logic p, input logic [W-1:0] d, input logic po,
                        input logic ad, input string req);
        logic [W:0] s;
        m_ovf = 1'b0; m_udf = 1'b0;
        if (ad) begin
            if (model.size() < 2) m_udf = 1'b1;
            else begin
                s = {1'b0, model[0]} + {1'b0, model[1]};
                void'(model.pop_front());
                void'(model.pop_front());
                model.push_front(s[W-1:0]);
                m_carry = s[W];
            end
        end else if (po) begin
            if (model.size() == 0) m_udf = 1'b1;
            else void'(model.pop_front());
        end else if (p) begin
            if (model.size() == D) m_ovf = 1'b1;
            else model.push_front(d);
        end
        push_i = p; push_data_i = d; pop_i = po; add_i = ad;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; add_i = 1'b0;
        compare(req);
    endtask

    task automatic idle(input string req);
        step(1'b0, '0, 1'b0, 1'b0, req);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // Sweep every fill level against every command combination.
        for (int n = 0; n <= D; n++) begin
            for (int c = 0; c < 8; c++) begin
                string req;
                int nset;
                do_reset();
                for (int k = 0; k < n; k++)
                    step(1'b1, W'(16'hF000 + n * 16'h0111 + k * 16'h1357), 1'b0, 1'b0, "R2");
                nset = (c & 1) + ((c >> 1) & 1) + ((c >> 2) & 1);
                if (nset > 1)          req = "R8";
                else if (c[2])         req = (n < 2) ? "R7" : "R6";
                else if (c[1])         req = (n == 0) ? "R4" : "R3";
                else if (c[0])         req = (n == D) ? "R5" : "R2";
                else                   req = "R9";
                step(c[0], W'(16'hA5A5 ^ (n << 4) ^ c), c[1], c[2], req);
                idle("R9");
                while (model.size() > 0) step(1'b0, '0, 1'b1, 1'b0, "R3");
                step(1'b0, '0, 1'b1, 1'b0, "R4");
                idle("R9");
            end
        end

        // Carry behaviour and its hold.
        do_reset();
        step(1'b1, 16'hFFFF, 1'b0, 1'b0, "R2");
        step(1'b1, 16'h0001, 1'b0, 1'b0, "R2");
        step(1'b0, '0, 1'b0, 1'b1, "R6");
        step(1'b1, 16'h1234, 1'b0, 1'b0, "R10");
        step(1'b0, '0, 1'b1, 1'b0, "R10");
        step(1'b0, '0, 1'b0, 1'b1, "R7");
        idle("R10");
        step(1'b1, 16'h0002, 1'b0, 1'b0, "R2");
        step(1'b0, '0, 1'b0, 1'b1, "R6");
        step(1'b1, 16'h8000, 1'b0, 1'b0, "R2");
        step(1'b1, 16'h8000, 1'b0, 1'b0, "R2");
        step(1'b0, '0, 1'b0, 1'b1, "R6");
        step(1'b0, '0, 1'b0, 1'b1, "R6");
        idle("R10");

        // Chain of adds over a full stack.
        do_reset();
        for (int k = 0; k < D; k++) step(1'b1, W'(16'h2000 * (k + 1)), 1'b0, 1'b0, "R2");
        step(1'b1, 16'hDEAD, 1'b0, 1'b0, "R5");
        for (int k = 0; k < D - 1; k++) step(1'b0, '0, 1'b0, 1'b1, "R6");
        step(1'b0, '0, 1'b0, 1'b1, "R7");
        idle("R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule